// File: doc/BRIEF.md
# Asynchronous Strobe-Framed Register Read Port

This block is the read side of a parallel host bus for a peripheral. The host drives two active-low strobes, a chip select and a read enable, with no clock. A read cycle is the interval during which both strobes are low. The block brings both strobes into the system clock through a synchronizer and finds the start and the end of each cycle. At the start it decodes a halfword address in a 256-byte space and captures the selected word. That word then drives the data lanes for the rest of the cycle, and an output enable per 16-bit lane goes to the bus pads.

Free-running counters are captured into a holding register when a cycle starts, so the host sees one coherent value. In half-width mode the host reads a 32-bit register as two halfwords. Only the access to the lower half captures a counter, and the access to the upper half returns the stored copy. Two receive FIFO windows produce one pop pulse when a cycle that reads them ends. A cycle that is too short to be a real access does not pop.

Top module: `hbus_rd_port`

## Requirements
- R1: After reset, `d_oe_lo`, `d_oe_hi`, both pop outputs and `d_out` are 0, and every counter holding register is 0.
- R2: A cycle starts only when both `cs_n` and `rd_n` are low, and they may fall in either order. `d_oe_lo` rises on the third rising clock edge after the later strobe falls (two synchronizer stages plus the framing register).
- R3: A cycle ends when either strobe returns high, whichever rises first, and `d_oe_lo` falls on the third edge after that rise. A new cycle needs MIN_GAP (default 2) consecutive synchronized samples with a strobe high. If the gap is shorter, no cycle starts until the strobes go high again.
- R4: The word returned is captured when the cycle starts and stays constant on `d_out` while `d_oe_lo` is high.
- R5: Counter 0 sits at byte offset 0x60 and counter 1 at 0x64. A read returns the counter value present at the start of the cycle, and later changes to `cnt_live` do not alter it.
- R6: In half-width mode (`half_mode`=1), `d_oe_hi` stays 0 and `d_out[15:0]` carries one half of the word. `addr[0]` selects that half: 1 gives bits 31:16 and 0 gives bits 15:0. In full-width mode `d_oe_hi` follows `d_oe_lo`.
- R7: In half-width mode a counter is captured only on the access with `addr[0]`=0. An access with `addr[0]`=1 returns the upper half of the stored copy.
- R8: The receive data window sits at byte 0x00 and the receive status window at 0x40. Reading a window gives a single one-clock pop on `rx_data_pop` or `rx_stat_pop` on the edge where `d_oe_lo` falls. In half-width mode the pop comes only from the `addr[0]`=1 access.
- R9: A cycle that lasts fewer than MIN_ASSERT (default 4) synchronized samples produces no pop.
- R10: Any location that is not mapped reads as 0 and produces no pop.
- R11: Byte offset 0x50 returns `status_word` as captured at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Asynchronous chip select, active low |
| rd_n | input | 1 | Asynchronous read enable, active low |
| addr | input | 7 | Byte address bits 7..1; bit 0 of this port is the halfword select |
| half_mode | input | 1 | 1 selects 16-bit bus mode |
| status_word | input | 32 | Plain status register contents |
| rx_data_head | input | 32 | Word at the head of the receive data FIFO |
| rx_stat_head | input | 32 | Word at the head of the receive status FIFO |
| cnt_live | input | 64 | Live values of the two free-running counters, counter 0 in the low word |
| d_out | output | 32 | Data presented to the bus pads |
| d_oe_lo | output | 1 | Output enable for lanes 15:0 |
| d_oe_hi | output | 1 | Output enable for lanes 31:16 |
| rx_data_pop | output | 1 | One-clock pop request to the receive data FIFO |
| rx_stat_pop | output | 1 | One-clock pop request to the receive status FIFO |

## Verification
The hardest cases to reach from the ports are the timing windows of the synchronized strobe. One is a gap between cycles that is one clock shorter than the minimum. The other is a strobe pulse too short to count as a real access. The stimulus places strobe edges on falling clock edges and counts the synchronizer stages, so the gap is exactly one sample wide and the pulse spans exactly two samples. Counter coherence is tested by changing `cnt_live` partway through every cycle, and by reading both halves of a counter in half-width mode with a change between them. Random reads mix strobe order, bus width and address.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
    localparam int DATA_W  = 32;
    localparam int HALF_W  = 16;
    localparam int ADDR_W  = 7;
    localparam int WIDX_W  = ADDR_W - 1;
    localparam int NUM_CNT = 2;
    localparam int CIDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

    localparam logic [WIDX_W-1:0] WIDX_RXDATA   = 6'h00;
    localparam logic [WIDX_W-1:0] WIDX_RXSTAT   = 6'h10;
    localparam logic [WIDX_W-1:0] WIDX_STATUS   = 6'h14;
    localparam logic [WIDX_W-1:0] WIDX_CNT_BASE = 6'h18;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RXDATA,
        SEL_RXSTAT,
        SEL_STATUS,
        SEL_CNT
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e           kind;
        logic [CIDX_W-1:0]   cidx;
        logic                upper;
    } sel_t;

    function automatic sel_t decode_addr(input logic [ADDR_W-1:0] a);
        sel_t s;
        logic [WIDX_W-1:0] w;
        w       = a[ADDR_W-1:1];
        s.kind  = SEL_NONE;
        s.cidx  = '0;
        s.upper = a[0];
        if (w == WIDX_RXDATA)
            s.kind = SEL_RXDATA;
        else if (w == WIDX_RXSTAT)
            s.kind = SEL_RXSTAT;
        else if (w == WIDX_STATUS)
            s.kind = SEL_STATUS;
        else if (w >= WIDX_CNT_BASE && w < WIDX_CNT_BASE + WIDX_W'(NUM_CNT)) begin
            s.kind = SEL_CNT;
            s.cidx = CIDX_W'(w - WIDX_CNT_BASE);
        end
        return s;
    endfunction

    function automatic logic [HALF_W-1:0] pick_half(input logic [DATA_W-1:0] w, input logic upper);
        return upper ? w[DATA_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction
endpackage

// File: rtl/hbus_frame.sv
module hbus_frame #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_ASSERT  = 4,
    parameter int MIN_GAP     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_n,
    output logic start_c,
    output logic end_c,
    output logic on_q,
    output logic long_ok
);
    localparam int GAP_W  = $clog2(MIN_GAP + 1);
    localparam int HOLD_W = $clog2(MIN_ASSERT + 1);

    logic [SYNC_STAGES-1:0] cs_sh, rd_sh;
    logic [GAP_W-1:0]       gap_cnt;
    logic [HOLD_W-1:0]      hold_cnt;
    logic                   both_low, gap_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_sh <= '1;
            rd_sh <= '1;
        end else begin
            cs_sh <= {cs_sh[SYNC_STAGES-2:0], cs_n};
            rd_sh <= {rd_sh[SYNC_STAGES-2:0], rd_n};
        end
    end

    assign both_low = ~cs_sh[SYNC_STAGES-1] & ~rd_sh[SYNC_STAGES-1];
    assign gap_ok   = (gap_cnt >= GAP_W'(MIN_GAP));
    assign start_c  = ~on_q & both_low & gap_ok;
    assign end_c    = on_q & ~both_low;
    assign long_ok  = (hold_cnt >= HOLD_W'(MIN_ASSERT));

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q     <= 1'b0;
            gap_cnt  <= '0;
            hold_cnt <= '0;
        end else begin
            if (start_c)
                on_q <= 1'b1;
            else if (end_c)
                on_q <= 1'b0;

            if (both_low)
                gap_cnt <= '0;
            else if (!gap_ok)
                gap_cnt <= gap_cnt + 1'b1;

            if (start_c)
                hold_cnt <= HOLD_W'(1);
            else if (on_q && both_low && !long_ok)
                hold_cnt <= hold_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hbus_cnt_snap.sv
module hbus_cnt_snap
    import hbus_pkg::*;
#(
    parameter int N = NUM_CNT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N*DATA_W-1:0] live,
    input  logic [N-1:0]        latch,
    output logic [N*DATA_W-1:0] snap
);
    for (genvar i = 0; i < N; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)
                snap[i*DATA_W +: DATA_W] <= '0;
            else if (latch[i])
                snap[i*DATA_W +: DATA_W] <= live[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/hbus_rd_mux.sv
module hbus_rd_mux
    import hbus_pkg::*;
(
    input  sel_t                      sel,
    input  logic                      half,
    input  logic [DATA_W-1:0]         status_word,
    input  logic [DATA_W-1:0]         rx_data_head,
    input  logic [DATA_W-1:0]         rx_stat_head,
    input  logic [NUM_CNT*DATA_W-1:0] cnt_live,
    input  logic [NUM_CNT*DATA_W-1:0] cnt_snap,
    output logic [NUM_CNT-1:0]        latch_req,
    output logic [DATA_W-1:0]         word
);
    logic [DATA_W-1:0] full;

    always_comb begin
        latch_req = '0;
        full      = '0;
        case (sel.kind)
            SEL_RXDATA: full = rx_data_head;
            SEL_RXSTAT: full = rx_stat_head;
            SEL_STATUS: full = status_word;
            SEL_CNT: begin
                if (!half || !sel.upper) begin
                    latch_req[sel.cidx] = 1'b1;
                    full = cnt_live[sel.cidx*DATA_W +: DATA_W];
                end else begin
                    full = cnt_snap[sel.cidx*DATA_W +: DATA_W];
                end
            end
            default: full = '0;
        endcase
        word = half ? {{(DATA_W-HALF_W){1'b0}}, pick_half(full, sel.upper)} : full;
    end
endmodule

// File: rtl/hbus_rd_port.sv
module hbus_rd_port
    import hbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_ASSERT  = 4,
    parameter int MIN_GAP     = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cs_n,
    input  logic                      rd_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      half_mode,
    input  logic [DATA_W-1:0]         status_word,
    input  logic [DATA_W-1:0]         rx_data_head,
    input  logic [DATA_W-1:0]         rx_stat_head,
    input  logic [NUM_CNT*DATA_W-1:0] cnt_live,
    output logic [DATA_W-1:0]         d_out,
    output logic                      d_oe_lo,
    output logic                      d_oe_hi,
    output logic                      rx_data_pop,
    output logic                      rx_stat_pop
);
    logic                      start_c, end_c, on_q, long_ok;
    sel_t                      dec_now;
    logic [NUM_CNT-1:0]        latch_req;
    logic [NUM_CNT*DATA_W-1:0] cnt_snap;
    logic [DATA_W-1:0]         mux_word, dout_q;
    sel_kind_e                 kind_q;
    logic                      upper_q, mode_q, pop_d_q, pop_s_q;
    logic                      sel_none;

    hbus_frame #(
        .SYNC_STAGES(SYNC_STAGES),
        .MIN_ASSERT (MIN_ASSERT),
        .MIN_GAP    (MIN_GAP)
    ) u_frame (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .start_c(start_c),
        .end_c  (end_c),
        .on_q   (on_q),
        .long_ok(long_ok)
    );

    assign dec_now = decode_addr(addr);

    hbus_rd_mux u_mux (
        .sel         (dec_now),
        .half        (half_mode),
        .status_word (status_word),
        .rx_data_head(rx_data_head),
        .rx_stat_head(rx_stat_head),
        .cnt_live    (cnt_live),
        .cnt_snap    (cnt_snap),
        .latch_req   (latch_req),
        .word        (mux_word)
    );

    hbus_cnt_snap #(.N(NUM_CNT)) u_snap (
        .clk  (clk),
        .rst  (rst),
        .live (cnt_live),
        .latch(latch_req & {NUM_CNT{start_c}}),
        .snap (cnt_snap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= SEL_NONE;
            upper_q <= 1'b0;
            mode_q  <= 1'b0;
            dout_q  <= '0;
            pop_d_q <= 1'b0;
            pop_s_q <= 1'b0;
        end else begin
            pop_d_q <= 1'b0;
            pop_s_q <= 1'b0;
            if (start_c) begin
                kind_q  <= dec_now.kind;
                upper_q <= dec_now.upper;
                mode_q  <= half_mode;
                dout_q  <= mux_word;
            end
            if (end_c && long_ok && (!mode_q || upper_q)) begin
                pop_d_q <= (kind_q == SEL_RXDATA);
                pop_s_q <= (kind_q == SEL_RXSTAT);
            end
        end
    end

    assign sel_none    = (kind_q == SEL_NONE);
    assign d_out       = dout_q;
    assign d_oe_lo     = on_q;
    assign d_oe_hi     = on_q & ~mode_q;
    assign rx_data_pop = pop_d_q;
    assign rx_stat_pop = pop_s_q;
endmodule

// File: rtl/hbus_rd_port_chk.sv
module hbus_rd_port_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] d_out,
    input logic        d_oe_lo,
    input logic        d_oe_hi,
    input logic        rx_data_pop,
    input logic        rx_stat_pop,
    input logic        mode_q,
    input logic        sel_none
);
    AST_HALF_UPPER_FLOAT: assert property (@(posedge clk) disable iff (rst)
        d_oe_hi |-> (d_oe_lo && !mode_q)); // R6

    AST_POP_AT_END: assert property (@(posedge clk) disable iff (rst)
        (rx_data_pop || rx_stat_pop) |-> (!d_oe_lo && $past(d_oe_lo))); // R8

    AST_POP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_data_pop, rx_stat_pop})); // R8

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (d_oe_lo && $past(d_oe_lo)) |-> $stable(d_out)); // R4

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (d_oe_lo && sel_none) |-> (d_out == 32'h0)); // R10

    AST_GAP_HONOURED: assert property (@(posedge clk) disable iff (rst)
        $fell(d_oe_lo) |=> !d_oe_lo); // R3
endmodule

bind hbus_rd_port hbus_rd_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .d_out      (d_out),
    .d_oe_lo    (d_oe_lo),
    .d_oe_hi    (d_oe_hi),
    .rx_data_pop(rx_data_pop),
    .rx_stat_pop(rx_stat_pop),
    .mode_q     (mode_q),
    .sel_none   (sel_none)
);

// File: tb/tb_hbus_rd_port.sv
module tb_hbus_rd_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, rd_n = 1'b1;
    logic [6:0]  addr = '0;
    logic        half_mode = 1'b0;
    logic [31:0] status_word = 32'h0, rx_data_head = 32'h0, rx_stat_head = 32'h0;
    logic [63:0] cnt_live = 64'h0;
    logic [31:0] d_out;
    logic        d_oe_lo, d_oe_hi, rx_data_pop, rx_stat_pop;

    int checks = 0;
    int errors = 0;
    int n_dpop = 0;
    int n_spop = 0;
    logic [31:0] snap_m [2];

    always #10 clk = ~clk;

    hbus_rd_port dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .addr(addr),
        .half_mode(half_mode), .status_word(status_word),
        .rx_data_head(rx_data_head), .rx_stat_head(rx_stat_head),
        .cnt_live(cnt_live), .d_out(d_out), .d_oe_lo(d_oe_lo),
        .d_oe_hi(d_oe_hi), .rx_data_pop(rx_data_pop), .rx_stat_pop(rx_stat_pop)
    );

    always @(posedge clk) begin
        if (!rst && rx_data_pop) n_dpop++;
        if (!rst && rx_stat_pop) n_spop++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected word from the requirements; updates the holding model
    function automatic logic [31:0] model_read(input logic [6:0] a, input logic half);
        logic [5:0]  w;
        logic [31:0] v;
        w = a[6:1];
        v = 32'h0;
        case (w)
            6'h00: v = rx_data_head;
            6'h10: v = rx_stat_head;
            6'h14: v = status_word;
            6'h18, 6'h19: begin
                if (!half || !a[0]) snap_m[w[0]] = cnt_live[w[0]*32 +: 32];
                v = snap_m[w[0]];
            end
            default: v = 32'h0;
        endcase
        if (half) v = {16'h0, a[0] ? v[31:16] : v[15:0]};
        return v;
    endfunction

    function automatic bit is_fifo(input logic [6:0] a, output bit data_win);
        data_win = (a[6:1] == 6'h00);
        return (a[6:1] == 6'h00) || (a[6:1] == 6'h10);
    endfunction

    task automatic do_read(input logic [6:0] a, input logic half, input bit cs_first, input bit cs_up_first);
        logic [31:0] exp;
        bit fifo, dwin;
        int d0, s0;
        @(negedge clk);
        addr = a;
        half_mode = half;
        @(negedge clk);
        if (cs_first) cs_n = 1'b0; else rd_n = 1'b0;
        @(negedge clk);
        if (cs_first) rd_n = 1'b0; else cs_n = 1'b0;
        exp = model_read(a, half);
        repeat (4) @(negedge clk);
        cnt_live = {$urandom, $urandom};   // change after the cycle has started (R5)
        repeat (3) @(negedge clk);
        chk(d_oe_lo == 1'b1, "R2 oe_lo during cycle", {31'h0, d_oe_lo}, 32'h1);
        chk(d_oe_hi == !half, "R6 oe_hi per width", {31'h0, d_oe_hi}, {31'h0, !half});
        if (half)
            chk(d_out[15:0] == exp[15:0], "R5/R6/R7/R11 half data", {16'h0, d_out[15:0]}, exp);
        else
            chk(d_out == exp, "R5/R10/R11 word data", d_out, exp);
        d0 = n_dpop;
        s0 = n_spop;
        if (cs_up_first) cs_n = 1'b1; else rd_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(d_oe_lo == 1'b0, "R3 oe released", {31'h0, d_oe_lo}, 32'h0);
        fifo = is_fifo(a, dwin);
        chk(n_dpop - d0 == ((fifo && dwin && (!half || a[0])) ? 1 : 0), "R8/R10 data pop count",
            n_dpop - d0, (fifo && dwin && (!half || a[0])) ? 1 : 0);
        chk(n_spop - s0 == ((fifo && !dwin && (!half || a[0])) ? 1 : 0), "R8/R10 status pop count",
            n_spop - s0, (fifo && !dwin && (!half || a[0])) ? 1 : 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int d0;
        void'($urandom(32'd4242));
        snap_m[0] = 32'h0;
        snap_m[1] = 32'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(d_oe_lo == 1'b0 && d_oe_hi == 1'b0, "R1 oe after reset", {30'h0, d_oe_hi, d_oe_lo}, 32'h0);
        chk(rx_data_pop == 1'b0 && rx_stat_pop == 1'b0, "R1 pops after reset", {30'h0, rx_stat_pop, rx_data_pop}, 32'h0);
        chk(d_out == 32'h0, "R1 data after reset", d_out, 32'h0);
        repeat (3) @(negedge clk);

        // R1/R7: upper half of a counter before any capture reads zero
        cnt_live = 64'h1234_5678_9ABC_DEF0;
        do_read(7'h33, 1'b1, 1'b1, 1'b1);
        // R7: lower then upper, counter changes in between
        cnt_live = 64'hCAFE_F00D_0BAD_BEEF;
        do_read(7'h30, 1'b1, 1'b0, 1'b1);
        do_read(7'h31, 1'b1, 1'b1, 1'b0);
        // R5 full-width counter reads, R11 status
        status_word = 32'h5A5A_0F0F;
        do_read(7'h32, 1'b0, 1'b1, 1'b0);
        do_read(7'h28, 1'b0, 1'b0, 1'b0);
        // R8 FIFO windows, both widths
        rx_data_head = 32'h1111_2222;
        rx_stat_head = 32'h3333_4444;
        do_read(7'h00, 1'b0, 1'b1, 1'b1);
        do_read(7'h20, 1'b0, 1'b0, 1'b1);
        do_read(7'h00, 1'b1, 1'b1, 1'b0);
        do_read(7'h01, 1'b1, 1'b0, 1'b0);
        // R10 unmapped
        do_read(7'h7E, 1'b0, 1'b1, 1'b1);

        // R9 short pulse on the data window gives no pop
        @(negedge clk);
        addr = 7'h00;
        half_mode = 1'b0;
        d0 = n_dpop;
        cs_n = 1'b0;
        rd_n = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        rd_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(n_dpop == d0, "R9 short cycle pop", n_dpop - d0, 32'h0);

        // R3 gap of one sample does not start a new cycle
        addr = 7'h28;
        cs_n = 1'b0;
        rd_n = 1'b0;
        repeat (7) @(negedge clk);
        chk(d_oe_lo == 1'b1, "R2 cycle before short gap", {31'h0, d_oe_lo}, 32'h1);
        rd_n = 1'b1;
        @(negedge clk);
        rd_n = 1'b0;
        repeat (8) @(negedge clk);
        chk(d_oe_lo == 1'b0, "R3 short gap ignored", {31'h0, d_oe_lo}, 32'h0);
        cs_n = 1'b1;
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        do_read(7'h28, 1'b0, 1'b1, 1'b0);

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [6:0] a;
            int pick;
            pick = $urandom_range(0, 10);
            case (pick)
                0: a = 7'h00;  1: a = 7'h01;  2: a = 7'h20;  3: a = 7'h21;
                4: a = 7'h28;  5: a = 7'h29;  6: a = 7'h30;  7: a = 7'h31;
                8: a = 7'h32;  9: a = 7'h33;
                default: a = 7'($urandom);
            endcase
            status_word  = $urandom;
            rx_data_head = $urandom;
            rx_stat_head = $urandom;
            do_read(a, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule